// File: doc/BRIEF.md
# Parallel EPROM Read Sequencer

This block sits between a synchronous host and a slow asynchronous byte-wide read-only memory with a 12-bit address. The host offers an address on a valid/ready request channel. The block latches that address onto the memory bus, pulls chip enable low, and pulls output enable low some cycles later. Once every access delay has elapsed, it captures the data byte. On the next cycle it releases both enables and presents the byte on a valid/ready response channel.

All memory timing is counted in system clocks. Each nanosecond figure becomes a cycle count by rounding the ratio of time to clock period upward. A grade parameter selects the 350 ns or the 450 ns access time. In staggered mode, output enable is held off until its own shorter delay just fits inside the access window, so the late assertion costs no cycles. After the enables rise, the block waits out the output float time before it accepts another request. This keeps the memory's drivers off the shared bus before any reuse.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mem_ce_n and mem_oe_n are 1, rsp_valid is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. On the next cycle mem_addr equals the taken address. mem_addr stays unchanged while mem_ce_n is 0. When req_valid stays 0, mem_ce_n stays 1.
- R3: mem_ce_n goes to 0 on the cycle after a request is taken and stays 0 for exactly SAMPLE cycles. SAMPLE = max(ACC, LAG + OE). ACC, OE and DF are the access time, the output-enable delay and the float time, each divided by CLK_NS and rounded up. With the defaults (10 ns clock, fast grade) this gives ACC = 35, OE = 12, DF = 10.
- R4: In staggered mode, mem_oe_n falls LAG cycles after mem_ce_n falls, where LAG = ACC − OE when ACC > OE and 0 otherwise (23 with the defaults). mem_oe_n is 0 only while mem_ce_n is 0, and both rise on the same cycle.
- R5: mem_dq is sampled on the last clock edge of the chip-enable window. rsp_valid rises on the cycle the enables rise, and rsp_data carries the sampled byte.
- R6: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data stays unchanged. A response is consumed on an edge where both are 1.
- R7: req_ready is 0 from the cycle after a request is taken until both of these hold: DF cycles have passed since the enables rose, and the response has been consumed. It returns to 1 on exactly the first cycle where both hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a read address |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 12 | Byte address to read |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Host consumes the read byte |
| rsp_data | output | 8 | Read byte |
| mem_addr | output | 12 | Address lines toward the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | input | 8 | Data lines from the memory |

## Verification
A stuck or mis-counted access counter shows up as a chip-enable window one or more cycles off from SAMPLE, visible on the very access where it happens. If the window comes out short, the bench's memory model also returns corrupted data. A wrong output-enable compare moves the mem_oe_n fall away from cycle LAG. If output enable falls too late, the byte captured on that same access is wrong. A float counter that reloads or expires wrongly makes req_ready rise a cycle early or late after the enables rise, so the very next request is mistimed. A response register that drops or overwrites early changes rsp_valid or rsp_data during a stall of the host's rsp_ready.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

   // Whole clock cycles that cover a delay given in nanoseconds.
   function automatic int unsigned cyc_ceil(input int unsigned t_ns, input int unsigned clk_ns);
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Counter width able to hold the value n.
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/eprom_rd_seq.sv
// Access sequencer: holds the address, times the enable strobes and
// flags the capture edge.
module eprom_rd_seq #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned SAMPLE_CYC = 35,
   parameter int unsigned OE_LAG     = 23,
   parameter int unsigned CNT_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              busy,
   output logic              sample
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_CYC - 1);

   logic              active_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ce_n_q;

   assign sample = active_q && (cnt_q == LAST_CNT);
   assign busy   = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         ce_n_q   <= 1'b1;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         ce_n_q   <= 1'b0;
      end else if (sample) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         ce_n_q   <= 1'b1;
      end else if (active_q) begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (start) begin
         addr_q <= addr_in;
      end
   end

   assign mem_addr = addr_q;
   assign mem_ce_n = ce_n_q;

   generate
      if (OE_LAG == 0) begin : g_oe_with_ce
         assign mem_oe_n = ce_n_q;
      end else begin : g_oe_late
         localparam logic [CNT_W-1:0] LAG_CNT = CNT_W'(OE_LAG - 1);
         logic oe_n_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               oe_n_q <= 1'b1;
            end else if (sample) begin
               oe_n_q <= 1'b1;
            end else if (active_q && (cnt_q == LAG_CNT)) begin
               oe_n_q <= 1'b0;
            end
         end
         assign mem_oe_n = oe_n_q;
      end
   endgenerate

endmodule

// File: rtl/eprom_rd_resp.sv
// Response holding register with valid/ready handshake.
module eprom_rd_resp #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              rsp_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);

   logic              valid_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (sample) begin
         valid_q <= 1'b1;
      end else if (valid_q && rsp_ready) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (sample) begin
         data_q <= dq_in;
      end
   end

   assign rsp_valid = valid_q;
   assign rsp_data  = data_q;

endmodule

// File: rtl/eprom_rd_float.sv
// Bus-release timer: counts the float time from the enables' rise.
module eprom_rd_float #(
   parameter int unsigned DF_CYC = 10,
   parameter int unsigned FLT_W  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic release_bus,
   output logic quiet
);

   localparam logic [FLT_W-1:0] DF_LOAD = FLT_W'(DF_CYC);

   logic [FLT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (release_bus) begin
         left_q <= DF_LOAD;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign quiet = (left_q == '0);

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned CLK_NS       = 10,
   parameter bit          SLOW_GRADE   = 1'b0,
   parameter bit          OE_LATE      = 1'b1,
   parameter int unsigned TACC_FAST_NS = 350,
   parameter int unsigned TACC_SLOW_NS = 450,
   parameter int unsigned TOE_NS       = 120,
   parameter int unsigned TDF_NS       = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   input  logic [DATA_W-1:0] mem_dq
);
   import eprom_rd_pkg::*;

   localparam int unsigned TACC_NS    = SLOW_GRADE ? TACC_SLOW_NS : TACC_FAST_NS;
   localparam int unsigned ACC_CYC    = cyc_ceil(TACC_NS, CLK_NS);
   localparam int unsigned OE_CYC     = cyc_ceil(TOE_NS, CLK_NS);
   localparam int unsigned DF_CYC     = cyc_ceil(TDF_NS, CLK_NS);
   localparam int unsigned OE_LAG     = (OE_LATE && (ACC_CYC > OE_CYC)) ? (ACC_CYC - OE_CYC) : 0;
   localparam int unsigned SAMPLE_CYC = umax(ACC_CYC, OE_LAG + OE_CYC);
   localparam int unsigned CNT_W      = cnt_bits(SAMPLE_CYC);
   localparam int unsigned FLT_W      = cnt_bits(DF_CYC);

   // Elaboration-time parameter checks
   if (CLK_NS == 0) begin : g_bad_clk
      initial $fatal(1, "CLK_NS must be nonzero");
   end
   if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
      initial $fatal(1, "bus widths must be nonzero");
   end
   if (TOE_NS == 0 || TDF_NS == 0 || TACC_NS == 0) begin : g_bad_time
      initial $fatal(1, "all delays must be nonzero");
   end

   logic start;
   logic busy;
   logic sample;
   logic quiet;

   assign req_ready = !busy && quiet && !rsp_valid;
   assign start     = req_valid && req_ready;

   eprom_rd_seq #(
      .ADDR_W    (ADDR_W),
      .SAMPLE_CYC(SAMPLE_CYC),
      .OE_LAG    (OE_LAG),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .addr_in (req_addr),
      .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n),
      .busy    (busy),
      .sample  (sample)
   );

   eprom_rd_resp #(
      .DATA_W(DATA_W)
   ) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample   (sample),
      .dq_in    (mem_dq),
      .rsp_ready(rsp_ready),
      .rsp_valid(rsp_valid),
      .rsp_data (rsp_data)
   );

   eprom_rd_float #(
      .DF_CYC(DF_CYC),
      .FLT_W (FLT_W)
   ) u_float (
      .clk        (clk),
      .rst_n      (rst_n),
      .release_bus(sample),
      .quiet      (quiet)
   );

endmodule

// File: rtl/eprom_rd_chk.sv
module eprom_rd_chk #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned SAMPLE_CYC = 35,
   parameter int unsigned DF_CYC     = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [DATA_W-1:0] rsp_data,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n
);

   logic [15:0] low_run;
   logic [15:0] gap_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_run <= '0;
         gap_run <= 16'(DF_CYC);
      end else begin
         low_run <= mem_ce_n ? 16'd0 : low_run + 16'd1;
         if (!mem_ce_n) gap_run <= '0;
         else if (gap_run != 16'hFFFF) gap_run <= gap_run + 16'd1;
      end
   end

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |=> $stable(mem_addr));

   // R3
   ce_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |-> (low_run == 16'(SAMPLE_CYC)));

   // R4
   oe_within_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n);

   // R5
   rsp_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |-> $rose(rsp_valid));

   // R6
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

   // R7
   float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (gap_run >= 16'(DF_CYC)));

   // R7
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

endmodule

bind eprom_rd_ctrl eprom_rd_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .SAMPLE_CYC(SAMPLE_CYC),
   .DF_CYC    (DF_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_ready(req_ready),
   .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready),
   .rsp_data (rsp_data),
   .mem_addr (mem_addr),
   .mem_ce_n (mem_ce_n),
   .mem_oe_n (mem_oe_n)
);

// File: tb/tb_eprom_rd_ctrl.sv
module tb_eprom_rd_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int T_ACC = 350, T_OE = 120, T_DF = 100;
   localparam int ACC = (T_ACC + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int OEC = (T_OE + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int DF  = (T_DF + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int LAG = (ACC > OEC) ? ACC - OEC : 0;
   localparam int SAMPLE = (ACC > LAG + OEC) ? ACC : LAG + OEC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [11:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [7:0]  rsp_data;
   logic [11:0] mem_addr;
   logic        mem_ce_n;
   logic        mem_oe_n;
   logic [7:0]  mem_dq;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eprom_rd_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_dq(mem_dq)
   );

   function automatic logic [7:0] rom(input logic [11:0] a);
      return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
   endfunction

   // Memory model: data valid only once every delay has elapsed.
   int ce_age = 0, oe_age = 0, ad_age = 0;
   logic [11:0] ad_q = '0;
   always @(posedge clk) begin
      ce_age <= mem_ce_n ? 0 : ce_age + 1;
      oe_age <= mem_oe_n ? 0 : oe_age + 1;
      ad_age <= (mem_addr == ad_q) ? ad_age + 1 : 1;
      ad_q   <= mem_addr;
   end
   wire ad_ok = (mem_addr == ad_q) && (ad_age + 1 >= ACC);
   assign mem_dq = (ce_age + 1 >= ACC && oe_age + 1 >= OEC && ad_ok) ? rom(mem_addr) : ~rom(mem_addr);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [11:0] a, input int d);
      int ce_low, oe_fall, g;
      logic [7:0] held;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a;
      check(mem_addr == a, "R2 addr", mem_addr, a);
      ce_low = 0; oe_fall = -1;
      while (!mem_ce_n && ce_low < 1000) begin
         if (!mem_oe_n && oe_fall < 0) oe_fall = ce_low;
         if (req_ready) check(1'b0, "R7 ready during access", 1, 0);
         if (mem_addr != a) check(1'b0, "R2 addr stable", mem_addr, a);
         ce_low++;
         @(negedge clk);
      end
      check(ce_low == SAMPLE, "R3 ce width", ce_low, SAMPLE);
      check(oe_fall == LAG, "R4 oe lag", oe_fall, LAG);
      check(mem_oe_n == 1'b1, "R4 oe rises with ce", mem_oe_n, 1);
      check(rsp_valid == 1'b1, "R5 rsp_valid", rsp_valid, 1);
      check(rsp_data == rom(a), "R5 rsp_data", rsp_data, rom(a));
      held = rsp_data;
      g = 0;
      while (!req_ready && g < 1000) begin
         if (g == d) rsp_ready = 1'b1;
         if (g <= d && (!rsp_valid || rsp_data != held))
            check(1'b0, "R6 rsp held", rsp_data, held);
         g++;
         @(negedge clk);
      end
      rsp_ready = 1'b0;
      check(g == ((DF > d + 1) ? DF : d + 1), "R7 ready gap", g, (DF > d + 1) ? DF : d + 1);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: during reset
      check(mem_ce_n && mem_oe_n, "R1 enables in reset", {mem_ce_n, mem_oe_n}, 3);
      check(!rsp_valid, "R1 rsp_valid in reset", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n && mem_oe_n, "R1 enables after reset", {mem_ce_n, mem_oe_n}, 3);
      check(!rsp_valid, "R1 rsp_valid after reset", rsp_valid, 0);
      check(req_ready, "R1 req_ready after reset", req_ready, 1);
      // R2: no request, no access
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!mem_ce_n) check(1'b0, "R2 idle ce", mem_ce_n, 1);
      end
      check(mem_ce_n, "R2 idle ce", mem_ce_n, 1);
      do_read(12'h000, 0);
      do_read(12'hFFF, 0);
      do_read(12'hFFF, 25);
      for (int i = 0; i < 300; i++)
         do_read(12'((i * 137 + 5) & 12'hFFF), i % 14);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule